// File: doc/BRIEF.md
# SDRAM Start-Up Sequencer

This block owns the SDRAM command bus from reset until the memory can accept normal traffic. For a parameterised stabilisation period it keeps clock enable high, every data mask high and a no-operation command on the bus. It then closes both banks with a single precharge-all, gives the banks the precharge recovery time, and issues a parameterised number of auto-refresh commands. The last step writes the mode register with burst length, burst type and CAS latency taken from configuration inputs.

While the sequence runs, a busy output tells the surrounding controller to keep its own command sources off the bus. Once the settling time after the mode write has passed, a done flag rises and stays high until the next reset. All bus outputs come straight from registers. Bus cycle 0 is the interval between reset release and the first rising clock edge, and bus cycle p is the interval after the p-th rising edge. In the requirements below, W is WAIT_CYC, P is T_RP, C is T_RC, S is T_RSC and N is REF_CNT.

Top module: `sdram_init_seq`

## Requirements
- R1: During reset and in every cycle afterwards, sd_cke is 1 and every sd_dqm bit is 1. Bus cycles 0 to W-1 carry the no-operation command. Commands are written as {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, and no-operation is 0111.
- R2: Bus cycle W carries precharge (0010) with address bit 10 set, all other address bits 0, and bank 0.
- R3: Bus cycles W+1 to W+P-1 carry no-operation, and the first auto-refresh (0001, address 0) appears in cycle W+P.
- R4: Exactly N auto-refresh commands appear, in cycles W+P+k*C for k = 0 to N-1, with no-operation in every cycle between them. N below 8 is rejected at elaboration.
- R5: The mode write (0000) appears once, in cycle M = W+P+N*C, with address bits 7 to 10 equal to 0 and bank 0.
- R6: In the mode write, address bits 1:0 equal cfg_burst_len (code 0 gives length 1, 1 gives 2, 2 gives 4, 3 gives 8), address bit 2 is 0, and address bit 3 equals cfg_interleave (0 is sequential, 1 is interleaved).
- R7: In the mode write, address bits 6:4 hold cfg_cas_lat zero-extended to three bits, except that a code of 0 is written as latency 1. The configuration inputs are sampled only at the edge that starts cycle M, and they have no effect on any other cycle.
- R8: init_done is 0 and init_busy is 1 from reset until cycle M+S. From cycle M+S+1 onward, init_done is 1 and init_busy is 0, the bus carries no-operation with address 0, and both flags hold until the next reset. A reset at any point returns the bus to the cycle-0 state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all activity on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_burst_len | input | 2 | Burst length code for the mode write |
| cfg_interleave | input | 1 | Burst type: 0 sequential, 1 interleaved |
| cfg_cas_lat | input | 2 | CAS latency 1 to 3 (0 is treated as 1) |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_cke | output | 1 | Clock enable, held high |
| sd_addr | output | ADDR_W | Address lines (precharge option, mode word) |
| sd_ba | output | BA_W | Bank address, always 0 |
| sd_dqm | output | DQM_W | Data masks, held high |
| init_busy | output | 1 | High while the sequence owns the bus |
| init_done | output | 1 | High once the memory is ready, until reset |

## Verification
A shared wait counter that is reloaded wrongly, or a refresh counter with a bad limit, moves the cycle in which a precharge, refresh or mode write appears. Every later command then lands on the wrong bus cycle, and the per-cycle comparison catches it at the first affected edge. A wrong mode field shows up only in the one mode-write cycle, so that cycle is checked field by field. Configuration is changed at random during the stabilisation hold to show that the inputs leak into no other cycle. A reset in the middle of the refresh phase shows that the sequence restarts.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

   // {cs_n, ras_n, cas_n, we_n}
   typedef enum logic [3:0] {
      CMD_MRS = 4'b0000,
      CMD_REF = 4'b0001,
      CMD_PRE = 4'b0010,
      CMD_NOP = 4'b0111
   } sd_cmd_t;

   typedef enum logic [2:0] {
      ST_HOLD,
      ST_WAIT_RP,
      ST_WAIT_RC,
      ST_WAIT_RSC,
      ST_READY
   } init_state_t;

   localparam int unsigned PRE_ALL_BIT = 10;
   localparam int unsigned MODE_BITS   = 7;

endpackage

// File: rtl/sdram_init_timer.sv
module sdram_init_timer #(
   parameter int unsigned CNT_W   = 16,
   parameter int unsigned RST_VAL = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= CNT_W'(RST_VAL);
      else if (load)
         cnt_q <= load_val;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign expired = (cnt_q == '0);

endmodule

// File: rtl/sdram_mode_word.sv
module sdram_mode_word #(
   parameter int unsigned ADDR_W = 11
) (
   input  logic [1:0]        bl_code,
   input  logic              interleave,
   input  logic [1:0]        cl_code,
   output logic [ADDR_W-1:0] word
);
   import sdram_init_pkg::*;

   logic [2:0] cl_field;

   always_comb begin
      cl_field = (cl_code == 2'd0) ? 3'd1 : {1'b0, cl_code};
   end

   assign word[1:0] = bl_code;
   assign word[2]   = 1'b0;
   assign word[3]   = interleave;
   assign word[6:4] = cl_field;

   // reserved bits above the mode field, including the precharge option bit
   for (genvar i = MODE_BITS; i < ADDR_W; i++) begin : g_zero
      assign word[i] = 1'b0;
   end

endmodule

// File: rtl/sdram_init_bus.sv
module sdram_init_bus #(
   parameter int unsigned ADDR_W = 11,
   parameter int unsigned BA_W   = 1,
   parameter int unsigned DQM_W  = 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  sdram_init_pkg::sd_cmd_t cmd_in,
   input  logic [ADDR_W-1:0]      addr_in,
   output logic                   cs_n,
   output logic                   ras_n,
   output logic                   cas_n,
   output logic                   we_n,
   output logic [ADDR_W-1:0]      addr,
   output logic [BA_W-1:0]        ba,
   output logic                   cke,
   output logic [DQM_W-1:0]       dqm
);
   import sdram_init_pkg::*;

   sd_cmd_t           cmd_q;
   logic [ADDR_W-1:0] addr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q  <= CMD_NOP;
         addr_q <= '0;
      end else begin
         cmd_q  <= cmd_in;
         addr_q <= addr_in;
      end
   end

   assign {cs_n, ras_n, cas_n, we_n} = cmd_q;
   assign addr = addr_q;
   assign ba   = '0;
   assign cke  = 1'b1;
   assign dqm  = '1;

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq #(
   parameter int unsigned WAIT_CYC = 50000,
   parameter int unsigned T_RP     = 3,
   parameter int unsigned T_RC     = 7,
   parameter int unsigned T_RSC    = 2,
   parameter int unsigned REF_CNT  = 8,
   parameter int unsigned ADDR_W   = 11,
   parameter int unsigned BA_W     = 1,
   parameter int unsigned DQM_W    = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        cfg_burst_len,
   input  logic              cfg_interleave,
   input  logic [1:0]        cfg_cas_lat,
   output logic              sd_cs_n,
   output logic              sd_ras_n,
   output logic              sd_cas_n,
   output logic              sd_we_n,
   output logic              sd_cke,
   output logic [ADDR_W-1:0] sd_addr,
   output logic [BA_W-1:0]   sd_ba,
   output logic [DQM_W-1:0]  sd_dqm,
   output logic              init_busy,
   output logic              init_done
);
   import sdram_init_pkg::*;

   localparam int unsigned MAX_A  = (WAIT_CYC > T_RC) ? WAIT_CYC : T_RC;
   localparam int unsigned MAX_B  = (T_RP > T_RSC) ? T_RP : T_RSC;
   localparam int unsigned MAX_V  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
   localparam int unsigned CNT_W  = $clog2(MAX_V + 1);
   localparam int unsigned RC_W   = $clog2(REF_CNT + 1);
   localparam logic [CNT_W-1:0] RP_RELOAD  = CNT_W'(T_RP - 1);
   localparam logic [CNT_W-1:0] RC_RELOAD  = CNT_W'(T_RC - 1);
   localparam logic [CNT_W-1:0] RSC_RELOAD = CNT_W'(T_RSC);
   localparam logic [RC_W-1:0]  REF_LAST   = RC_W'(REF_CNT);

   initial begin
      assert (WAIT_CYC >= 1) else $error("WAIT_CYC must be at least 1");
      assert (T_RP >= 1 && T_RC >= 1 && T_RSC >= 1) else $error("timing gaps must be at least 1");
      assert (REF_CNT >= 8) else $error("REF_CNT must be at least 8");
      assert (ADDR_W >= 11) else $error("ADDR_W must cover the precharge option bit");
      assert (BA_W >= 1 && DQM_W >= 1) else $error("bank and mask widths must be nonzero");
   end

   init_state_t       state_q, state_d;
   logic [RC_W-1:0]   refs_q, refs_d;
   logic              done_q, done_d;
   logic              busy_q;
   logic              tmr_load;
   logic [CNT_W-1:0]  tmr_val;
   logic              tmr_exp;
   sd_cmd_t           nxt_cmd;
   logic [ADDR_W-1:0] nxt_addr;
   logic [ADDR_W-1:0] mode_word;

   sdram_init_timer #(
      .CNT_W   (CNT_W),
      .RST_VAL (WAIT_CYC - 1)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .expired  (tmr_exp)
   );

   sdram_mode_word #(
      .ADDR_W (ADDR_W)
   ) u_mode (
      .bl_code    (cfg_burst_len),
      .interleave (cfg_interleave),
      .cl_code    (cfg_cas_lat),
      .word       (mode_word)
   );

   always_comb begin
      state_d  = state_q;
      refs_d   = refs_q;
      done_d   = done_q;
      tmr_load = 1'b0;
      tmr_val  = '0;
      nxt_cmd  = CMD_NOP;
      nxt_addr = '0;
      case (state_q)
         ST_HOLD: if (tmr_exp) begin
            nxt_cmd              = CMD_PRE;
            nxt_addr[PRE_ALL_BIT] = 1'b1;
            tmr_load             = 1'b1;
            tmr_val              = RP_RELOAD;
            state_d              = ST_WAIT_RP;
         end
         ST_WAIT_RP: if (tmr_exp) begin
            nxt_cmd  = CMD_REF;
            tmr_load = 1'b1;
            tmr_val  = RC_RELOAD;
            refs_d   = RC_W'(1);
            state_d  = ST_WAIT_RC;
         end
         ST_WAIT_RC: if (tmr_exp) begin
            tmr_load = 1'b1;
            if (refs_q == REF_LAST) begin
               nxt_cmd  = CMD_MRS;
               nxt_addr = mode_word;
               tmr_val  = RSC_RELOAD;
               state_d  = ST_WAIT_RSC;
            end else begin
               nxt_cmd = CMD_REF;
               tmr_val = RC_RELOAD;
               refs_d  = refs_q + 1'b1;
            end
         end
         ST_WAIT_RSC: if (tmr_exp) begin
            done_d  = 1'b1;
            state_d = ST_READY;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_HOLD;
         refs_q  <= '0;
         done_q  <= 1'b0;
         busy_q  <= 1'b1;
      end else begin
         state_q <= state_d;
         refs_q  <= refs_d;
         done_q  <= done_d;
         busy_q  <= ~done_d;
      end
   end

   sdram_init_bus #(
      .ADDR_W (ADDR_W),
      .BA_W   (BA_W),
      .DQM_W  (DQM_W)
   ) u_bus (
      .clk     (clk),
      .rst_n   (rst_n),
      .cmd_in  (nxt_cmd),
      .addr_in (nxt_addr),
      .cs_n    (sd_cs_n),
      .ras_n   (sd_ras_n),
      .cas_n   (sd_cas_n),
      .we_n    (sd_we_n),
      .addr    (sd_addr),
      .ba      (sd_ba),
      .cke     (sd_cke),
      .dqm     (sd_dqm)
   );

   assign init_done = done_q;
   assign init_busy = busy_q;

   logic [3:0] bus_cmd;
   assign bus_cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

   AST_PRE_ALL_BANKS: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_cmd == CMD_PRE) |-> sd_addr[PRE_ALL_BIT]);                             // R2
   AST_REF_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      refs_q <= REF_LAST);                                                         // R4
   AST_MRS_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_cmd == CMD_MRS) |-> (sd_addr[ADDR_W-1:MODE_BITS] == '0 && sd_ba == '0)); // R5
   AST_MRS_BL_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_cmd == CMD_MRS) |-> !sd_addr[2]);                                       // R6
   AST_MRS_CL_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_cmd == CMD_MRS) |-> (sd_addr[6:4] != 3'd0));                            // R7
   AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      init_done |=> init_done);                                                    // R8
   AST_BUSY_COMPLEMENT: assert property (@(posedge clk) disable iff (!rst_n)
      init_busy != init_done);                                                     // R8
   AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      init_done |-> (bus_cmd == CMD_NOP));                                         // R8

endmodule

// File: tb/sdram_init_seq_test.sv
module sdram_init_seq_test;

   localparam int CLK_PERIOD = 10;
   localparam int W   = 24;
   localparam int TRP = 3;
   localparam int TRC = 5;
   localparam int TRSC = 2;
   localparam int N   = 9;
   localparam int R0  = W + TRP;
   localparam int M   = R0 + N * TRC;
   localparam int LIMIT = 20000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  cfg_bl = 2'd0;
   logic        cfg_il = 1'b0;
   logic [1:0]  cfg_cl = 2'd2;
   logic        cs_n, ras_n, cas_n, we_n, cke;
   logic [10:0] addr;
   logic [0:0]  ba;
   logic [7:0]  dqm;
   logic        busy, done;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit finished = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sdram_init_seq #(
      .WAIT_CYC (W), .T_RP (TRP), .T_RC (TRC), .T_RSC (TRSC), .REF_CNT (N),
      .ADDR_W (11), .BA_W (1), .DQM_W (8)
   ) uut (
      .clk (clk), .rst_n (rst_n),
      .cfg_burst_len (cfg_bl), .cfg_interleave (cfg_il), .cfg_cas_lat (cfg_cl),
      .sd_cs_n (cs_n), .sd_ras_n (ras_n), .sd_cas_n (cas_n), .sd_we_n (we_n),
      .sd_cke (cke), .sd_addr (addr), .sd_ba (ba), .sd_dqm (dqm),
      .init_busy (busy), .init_done (done)
   );

   function automatic logic [3:0] exp_cmd(int c);
      if (c < W) return 4'b0111;
      if (c == W) return 4'b0010;
      if (c >= R0 && c < M && ((c - R0) % TRC) == 0) return 4'b0001;
      if (c == M) return 4'b0000;
      return 4'b0111;
   endfunction

   function automatic logic [10:0] exp_mode(logic [1:0] bl, logic il, logic [1:0] cl);
      logic [2:0] clf;
      clf = (cl == 2'd0) ? 3'd1 : {1'b0, cl};
      return {4'b0000, clf, il, 1'b0, bl};
   endfunction

   function automatic logic [10:0] exp_addr(int c, logic [1:0] bl, logic il, logic [1:0] cl);
      if (c == W) return 11'h400;
      if (c == M) return exp_mode(bl, il, cl);
      return 11'h000;
   endfunction

   function automatic string tag_of(int c);
      if (c < W) return "R1";
      if (c == W) return "R2";
      if (c < R0) return "R3";
      if (c < M) return "R4";
      if (c == M) return "R5";
      return "R8";
   endfunction

   task automatic check(bit ok, string tag, int c, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s cycle %0d actual %h expected %h", tag, c, act, exp);
      end
   endtask

   function automatic logic [31:0] bus_word();
      return {8'd0, done, busy, cke, &dqm, cs_n, ras_n, cas_n, we_n, ba, addr};
   endfunction

   task automatic run_trial(input logic [1:0] bl, input logic il, input logic [1:0] cl,
                            input bit scramble, input int stop_at);
      logic [31:0] act, exp;
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      // reset state: R1 for the bus, R8 for the flags
      check(cke && (&dqm) && {cs_n, ras_n, cas_n, we_n} == 4'b0111, "R1", -1,
            {cke, dqm, cs_n, ras_n, cas_n, we_n}, {1'b1, 8'hff, 4'b0111});
      check(busy && !done, "R8", -1, {busy, done}, 2'b10);
      cfg_bl = bl; cfg_il = il; cfg_cl = cl;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      for (int c = 0; c <= stop_at; c++) begin
         if (scramble && c < W - 1) begin
            cfg_bl = 2'($urandom); cfg_il = 1'($urandom); cfg_cl = 2'($urandom);
         end else begin
            cfg_bl = bl; cfg_il = il; cfg_cl = cl;
         end
         act = bus_word();
         exp = {8'd0, (c >= M + TRSC + 1), !(c >= M + TRSC + 1), 1'b1, 1'b1,
                exp_cmd(c), 1'b0, exp_addr(c, bl, il, cl)};
         check(act == exp, tag_of(c), c, act, exp);
         if (c == M) begin
            check(addr[3:0] == {il, 1'b0, bl}, "R6", c, addr[3:0], {il, 1'b0, bl});
            check(addr[6:4] == exp_mode(bl, il, cl)[6:4], "R7", c, addr[6:4], exp_mode(bl, il, cl)[6:4]);
         end
         @(negedge clk);
      end
   endtask

   initial begin
      void'($urandom(32'd1357));
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      // directed corners
      run_trial(2'd3, 1'b1, 2'd3, 1'b0, M + TRSC + 6);
      run_trial(2'd0, 1'b0, 2'd0, 1'b1, M + TRSC + 6);   // R7: code 0 written as 1
      run_trial(2'd2, 1'b0, 2'd1, 1'b0, R0 + 2 * TRC);   // R8: reset mid-refresh
      // random configurations with scrambled inputs during the hold
      for (int t = 0; t < 5; t++)
         run_trial(2'($urandom), 1'($urandom), 2'($urandom), 1'b1, M + TRSC + 6);
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > LIMIT && !finished) begin
         finished = 1;
         checks++;
         errors++;
         $display("FAIL watchdog actual %0d cycles expected at most %0d", cycles, LIMIT);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule